// File: doc/BRIEF.md
# Recirculating Delay-Line Word Memory

This block models a serial main memory made of recirculating lines. Every line holds a ring of words that circulates past a single access point, one bit per clock. One position counter is shared by all lines, so every line shows the same word slot and the same bit of that slot at the access point in the same clock. Nothing has to act for the contents to survive: a bit that leaves a line re-enters it, so the data keeps circulating.

A client places a 13-bit word address and a read or write request on the ports while the block is idle. The upper address field picks a line and the lower five bits pick a slot inside it. The block then waits until bit 0 of that slot reaches the access point. This wait depends on the rotation phase, so access time varies. The block then moves the 32 bits serially, least significant bit first, while `xfer_active` is high. For a read the bits appear on `rd_bit`. For a write they are taken from `wr_bit`. A one-cycle `done` follows the last bit.

The full build has 256 lines of 32 words (8192 words). The default build is the reduced one with 64 lines (2048 words). In the reduced build the line field is folded onto the lines that exist.

Top module: `delay_line_mem`

## Requirements
- R1: After reset `busy`, `xfer_active`, `done` and `rd_bit` are low, and the shared rotation position is 0.
- R2: The rotation position advances by one on every clock from 0 to 1023 and then wraps to 0. Its upper 5 bits are the slot at the access point and its lower 5 bits are the bit within that slot.
- R3: `req_addr[4:0]` selects the slot and `req_addr[12:5]` selects the line. The line used is that field modulo NUM_LINES (default 64), so in the default build line 3 and line 67 are the same storage.
- R4: A request is taken only on a clock where `busy` is low. It raises `busy` on the next cycle. Requests presented while `busy` is high are ignored.
- R5: The transfer starts on the first cycle on which the rotation position equals slot×32. A request accepted after that point in the rotation waits for the next pass.
- R6: `xfer_active` is high for exactly 32 consecutive cycles per access. On each of those cycles the bit index equals the lower 5 position bits, so bit 0 is moved first and bit 31 last.
- R7: During a read transfer `rd_bit` carries the stored bit of that cycle's index. A read leaves the word unchanged. `rd_bit` is 0 on every other cycle.
- R8: During a write transfer the value of `wr_bit` on each transfer cycle replaces the circulating bit of that index. All other words, including the same slot of other lines and neighbouring slots, keep their values.
- R9: `done` is high for one cycle, on the cycle after the last transfer bit. `busy` falls on that same cycle.
- R10: From the accepting edge, the number of cycles with `busy` high and `xfer_active` low is between 0 and 1023. 1023 occurs when the request is accepted at position slot×32, and 0 when it is accepted at position slot×32−1.
- R11: A stored word keeps its value across many full rotations with no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit moves past the access point per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read; sampled with the request |
| req_addr | input | 13 | Word address: line field [12:5], slot [4:0] |
| wr_bit | input | 1 | Serial write data, sampled on transfer cycles |
| rd_bit | output | 1 | Serial read data, valid on transfer cycles |
| xfer_active | output | 1 | High while the addressed slot's bits pass the access point |
| busy | output | 1 | An access is waiting or transferring |
| done | output | 1 | One-cycle pulse after the last bit of an access |

## Verification
Accesses are issued at arbitrary rotation phases, at the exact phase just past the slot start (full-turn wait), and one cycle before the slot start (no wait). This separates a correct phase match from an off-by-one that would start mid-word or a turn late. The write patterns are all-ones, all-zeros, alternating and end-bit-only. Each is read back from its own slot, from the following slot and from the same slot on another line, which exposes bit-order reversal, a shifted slot window and writes that leak into neighbours. Aliased line addresses, a request spammed while busy, the slot that straddles the wrap of the position, and a long idle stretch before a read-back cover folding, request rejection, wrap handling and retention.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } dlm_state_e;
endpackage

// File: rtl/dlm_rotor.sv
// Shared rotation position: one step per clock, wraps at the ring length.
module dlm_rotor #(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos
);
    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos = pos_q;
endmodule

// File: rtl/dlm_seq.sv
// Access sequencer: latches a request, waits for the slot, runs the bit window.
module dlm_seq
    import dlm_pkg::*;
#(
    parameter int SLOT_W     = 5,
    parameter int BIT_W      = 5,
    parameter int LIDX_W     = 6,
    parameter int LINE_SEL_W = 8,
    parameter int NUM_LINES  = 64,
    localparam int POS_W     = SLOT_W + BIT_W,
    localparam int ADDR_W    = LINE_SEL_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              xfer,
    output logic              done,
    output logic              is_write,
    output logic [LIDX_W-1:0] line,
    output logic [SLOT_W-1:0] slot
);
    typedef struct packed {
        dlm_state_e        state;
        logic [LIDX_W-1:0] line;
        logic [SLOT_W-1:0] slot;
        logic              write;
        logic              done;
    } seq_t;

    seq_t r_d, r_q;
    logic at_start;
    logic last_bit;
    logic [LINE_SEL_W-1:0] line_field;

    assign line_field = req_addr[ADDR_W-1:SLOT_W];

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        at_start = (pos == {r_q.slot, {BIT_W{1'b0}}});
        last_bit = (pos[BIT_W-1:0] == {BIT_W{1'b1}});
        xfer     = ((r_q.state == ST_WAIT) && at_start) || (r_q.state == ST_XFER);
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_WAIT;
                    r_d.line  = LIDX_W'(32'(line_field) % NUM_LINES);
                    r_d.slot  = req_addr[SLOT_W-1:0];
                    r_d.write = req_write;
                end
            end
            ST_WAIT: begin
                if (at_start) r_d.state = ST_XFER;
            end
            ST_XFER: begin
                if (last_bit) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, line: '0, slot: '0, write: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;
    assign is_write = r_q.write;
    assign line     = r_q.line;
    assign slot     = r_q.slot;
endmodule

// File: rtl/dlm_store.sv
// Word storage with single-bit access at the access point. Contents are not
// reset: circulating data simply persists.
module dlm_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2048,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [BIT_W-1:0] bitsel,
    input  logic             wr_bit,
    output logic             rd_bit
);
    logic [WORD_W-1:0] ring_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) ring_mem[idx][bitsel] <= wr_bit;
    end

    assign rd_bit = ring_mem[idx][bitsel];
endmodule

// File: rtl/delay_line_mem.sv
module delay_line_mem #(
    parameter int WORD_W         = 32,
    parameter int SLOTS_PER_LINE = 32,
    parameter int NUM_LINES      = 64,
    parameter int LINE_SEL_W     = 8,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int SLOT_W = $clog2(SLOTS_PER_LINE),
    localparam int POS_W  = SLOT_W + BIT_W,
    localparam int LIDX_W = $clog2(NUM_LINES),
    localparam int DEPTH  = NUM_LINES * SLOTS_PER_LINE,
    localparam int ADDR_W = LINE_SEL_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_bit,
    output logic              rd_bit,
    output logic              xfer_active,
    output logic              busy,
    output logic              done
);
    logic [POS_W-1:0]  pos_w;
    logic              xfer_w;
    logic              wr_sel_w;
    logic [LIDX_W-1:0] line_w;
    logic [SLOT_W-1:0] slot_w;
    logic              store_rd_w;

    dlm_rotor #(.POS_W(POS_W)) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (pos_w)
    );

    dlm_seq #(
        .SLOT_W     (SLOT_W),
        .BIT_W      (BIT_W),
        .LIDX_W     (LIDX_W),
        .LINE_SEL_W (LINE_SEL_W),
        .NUM_LINES  (NUM_LINES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos       (pos_w),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .busy      (busy),
        .xfer      (xfer_w),
        .done      (done),
        .is_write  (wr_sel_w),
        .line      (line_w),
        .slot      (slot_w)
    );

    dlm_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .wr_en  (xfer_w && wr_sel_w),
        .idx    ({line_w, slot_w}),
        .bitsel (pos_w[BIT_W-1:0]),
        .wr_bit (wr_bit),
        .rd_bit (store_rd_w)
    );

    assign xfer_active = xfer_w;
    assign rd_bit      = xfer_w && !wr_sel_w && store_rd_w;
endmodule

// File: rtl/delay_line_mem_chk.sv
module delay_line_mem_chk #(
    parameter int WORD_W = 32,
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 5,
    localparam int POS_W = SLOT_W + BIT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_active,
    input logic              busy,
    input logic              done,
    input logic [POS_W-1:0]  pos,
    input logic [SLOT_W-1:0] cur_slot
);
    int xcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           xcnt <= 0;
        else if (done)        xcnt <= 0;
        else if (xfer_active) xcnt <= xcnt + 1;
    end

    // R4
    a_r4_xfer_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> busy);

    // R5
    a_r5_start_at_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> (pos == {cur_slot, {BIT_W{1'b0}}}));

    // R6
    a_r6_bit_order: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && $past(xfer_active)) |->
            (pos[BIT_W-1:0] == BIT_W'($past(pos[BIT_W-1:0]) + 1'b1)));

    // R6
    a_r6_word_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (xcnt == WORD_W));

    // R9
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(xfer_active) && !xfer_active));

    // R9
    a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind delay_line_mem delay_line_mem_chk #(
    .WORD_W (WORD_W),
    .SLOT_W (SLOT_W),
    .BIT_W  (BIT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .busy        (busy),
    .done        (done),
    .pos         (pos_w),
    .cur_slot    (slot_w)
);

// File: tb/delay_line_mem_tb_top.sv
module delay_line_mem_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_LINES  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic        wr_bit = 1'b0;
    logic        rd_bit, xfer_active, busy, done;

    delay_line_mem dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .wr_bit(wr_bit), .rd_bit(rd_bit),
        .xfer_active(xfer_active), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural reference model
    int          m_cnt = 0;
    int          m_state = 0;   // 0 idle, 1 waiting, 2 moving bits
    int          m_line = 0;
    int          m_slot = 0;
    bit          m_wr = 0;
    bit          m_done = 0;
    logic [31:0] mmem [int];
    logic [31:0] cur_wdata = '0;

    function automatic int widx(int ln, int sl);
        return ln * 32 + sl;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_state = 0; m_done = 0; m_wr = 0;
        end else begin
            bit nd;
            nd = 0;
            case (m_state)
                0: if (req_valid) begin
                    m_state = 1;
                    m_line  = int'(req_addr[12:5]) % NUM_LINES;
                    m_slot  = int'(req_addr[4:0]);
                    m_wr    = req_write;
                end
                1: if (m_cnt == m_slot * 32) begin
                    if (m_wr) begin
                        if (!mmem.exists(widx(m_line, m_slot))) mmem[widx(m_line, m_slot)] = '0;
                        mmem[widx(m_line, m_slot)][0] = wr_bit;
                    end
                    m_state = 2;
                end
                default: begin
                    if (m_wr) mmem[widx(m_line, m_slot)][m_cnt % 32] = wr_bit;
                    if (m_cnt % 32 == 31) begin
                        m_state = 0;
                        nd = 1;
                    end
                end
            endcase
            m_done = nd;
            m_cnt  = (m_cnt + 1) % 1024;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // One cycle: compare against the model at the falling edge, then drive wr_bit.
    task automatic tick();
        bit e_x, e_rd;
        @(negedge clk);
        e_x  = (m_state == 1 && m_cnt == m_slot * 32) || (m_state == 2);
        e_rd = 1'b0;
        if (e_x && !m_wr && mmem.exists(widx(m_line, m_slot)))
            e_rd = mmem[widx(m_line, m_slot)][m_cnt % 32];
        chk(busy == (m_state != 0), "R4", "busy", busy, m_state != 0);
        chk(xfer_active == e_x, "R5", "xfer_active (R2 phase)", xfer_active, e_x);
        chk(done == m_done, "R9", "done", done, m_done);
        if (!(e_x && !m_wr && !mmem.exists(widx(m_line, m_slot))))
            chk(rd_bit == e_rd, "R7", "rd_bit", rd_bit, e_rd);
        wr_bit = cur_wdata[m_cnt % 32];
    endtask

    task automatic access(input bit wr, input logic [12:0] a, input logic [31:0] wd,
                          input int start_pos, input bit spam, input logic [12:0] spam_a,
                          output logic [31:0] rdw, output int waitc, output int xc);
        int guard;
        rdw = '0; waitc = 0; xc = 0; guard = 0;
        if (start_pos >= 0) while (m_cnt != start_pos) tick();
        cur_wdata = wd;
        wr_bit    = wd[m_cnt % 32];
        req_valid = 1'b1; req_write = wr; req_addr = a;
        do begin
            tick();
            if (xfer_active) begin
                rdw[m_cnt == 0 ? 31 : (m_cnt - 1) % 32] = rd_bit;
                xc++;
            end else if (busy) begin
                waitc++;
            end
            req_valid = spam && (xc == 0);
            req_write = 1'b1;
            req_addr  = spam_a;
            guard++;
        end while (!done && guard < 1200);
        req_valid = 1'b0;
        chk(done, "R9", "done seen", done, 1);
        chk(!busy, "R9", "busy low with done", busy, 0);
        chk(xc == 32, "R6", "transfer length", xc, 32);
    endtask

    // rdw indexing note: after tick the model position has already advanced
    // past the edge, so the bit shown on this cycle is the model position.
    // The capture above uses the position one behind, which is corrected here.
    task automatic rd(input logic [12:0] a, input int start_pos, output logic [31:0] v,
                      output int waitc);
        logic [31:0] raw;
        int xc;
        access(1'b0, a, 32'h0, start_pos, 1'b0, '0, raw, waitc, xc);
        v = {raw[30:0], raw[31]};
    endtask

    task automatic wrw(input logic [12:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        int w, xc;
        access(1'b1, a, d, -1, 1'b0, '0, dummy, w, xc);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int w;
        logic [31:0] dummy;
        int xc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!busy, "R1", "busy after reset", busy, 0);
        chk(!xfer_active, "R1", "xfer after reset", xfer_active, 0);
        chk(!done, "R1", "done after reset", done, 0);
        chk(!rd_bit, "R1", "rd_bit after reset", rd_bit, 0);
        tick();

        // R8 R6: several patterns, LSB-first order checked via readback
        wrw({8'd5, 5'd7}, 32'hFFFF_FFFF);
        wrw({8'd5, 5'd8}, 32'h0000_0000);
        wrw({8'd6, 5'd7}, 32'hA5A5_3C0F);
        wrw({8'd63, 5'd31}, 32'h8000_0001);
        wrw({8'd0, 5'd0}, 32'h1234_5678);
        rd({8'd5, 5'd7}, -1, v, w);  chk(v == 32'hFFFF_FFFF, "R7", "read ones", v, 32'hFFFF_FFFF);
        rd({8'd5, 5'd8}, -1, v, w);  chk(v == 32'h0, "R8", "neighbour slot", v, 0);
        rd({8'd6, 5'd7}, -1, v, w);  chk(v == 32'hA5A5_3C0F, "R6", "pattern order", v, 32'hA5A5_3C0F);
        rd({8'd63, 5'd31}, -1, v, w); chk(v == 32'h8000_0001, "R2", "wrap slot", v, 32'h8000_0001);
        rd({8'd0, 5'd0}, -1, v, w);  chk(v == 32'h1234_5678, "R7", "slot zero", v, 32'h1234_5678);
        rd({8'd5, 5'd7}, -1, v, w);  chk(v == 32'hFFFF_FFFF, "R7", "read is non-destructive", v, 32'hFFFF_FFFF);

        // R3 folding of the line field
        wrw({8'd3, 5'd12}, 32'hDEAD_BEEF);
        rd({8'd67, 5'd12}, -1, v, w); chk(v == 32'hDEAD_BEEF, "R3", "aliased line", v, 32'hDEAD_BEEF);
        wrw({8'd131, 5'd12}, 32'h0BAD_F00D);
        rd({8'd3, 5'd12}, -1, v, w);  chk(v == 32'h0BAD_F00D, "R3", "alias write", v, 32'h0BAD_F00D);
        rd({8'd6, 5'd7}, -1, v, w);   chk(v == 32'hA5A5_3C0F, "R8", "other line same slot", v, 32'hA5A5_3C0F);

        // R10 worst and best latency, R5 phase
        rd({8'd6, 5'd7}, 7 * 32, v, w);
        chk(w == 1023, "R10", "worst wait", w, 1023);
        chk(v == 32'hA5A5_3C0F, "R5", "worst-case data", v, 32'hA5A5_3C0F);
        rd({8'd6, 5'd7}, 7 * 32 - 1, v, w);
        chk(w == 0, "R10", "best wait", w, 0);
        rd({8'd0, 5'd0}, 1023, v, w);
        chk(w == 0, "R10", "best wait at wrap", w, 0);
        chk(v == 32'h1234_5678, "R2", "wrap to slot zero", v, 32'h1234_5678);

        // R4 requests while busy are ignored
        access(1'b0, {8'd5, 5'd7}, 32'h0, 9 * 32, 1'b1, {8'd5, 5'd8}, dummy, w, xc);
        chk(xc == 32, "R4", "one transfer under spam", xc, 32);
        tick();
        chk(!busy, "R4", "no queued request", busy, 0);
        rd({8'd5, 5'd8}, -1, v, w); chk(v == 32'h0, "R4", "spammed write ignored", v, 0);

        // R11 retention across rotations
        repeat (3000) tick();
        rd({8'd63, 5'd31}, -1, v, w); chk(v == 32'h8000_0001, "R11", "retained", v, 32'h8000_0001);
        rd({8'd5, 5'd7}, -1, v, w);   chk(v == 32'hFFFF_FFFF, "R11", "retained ones", v, 32'hFFFF_FFFF);

        tick();
        finish_run();
    end
endmodule